// File: doc/BRIEF.md
# Exposure-Controlled Transfer-Gate Sequencer

This block generates the line and frame timing for an image sensor. It produces a horizontal sync strobe once per line and a vertical sync strobe once per frame. Once per frame, at a fixed line inside the frame, it issues a transfer-gate strobe that moves the charge collected in the sensor array out to readout. Line length, frame length, strobe widths and the position of the transfer slot are all parameters. The line and frame counters run continuously from reset.

An external hold input, active low, lets a user stretch the exposure. The input is resynchronised into the clock domain. Its level is then sampled at each transfer slot. If the hold is asserted at that moment, the transfer strobe is withheld and the array keeps collecting charge. When the hold is released, nothing happens until the next regular slot, and that slot issues the transfer. Exposure therefore grows only in whole frames. A status output marks the frames during which the transfer is being held back. The hold input is honoured only while the normal-mode input is high.

Top module: `exp_tg_seq`

## Requirements
- R1: A synchronous active-high reset forces hdOut, vdOut, tgOut and integActive low and sets both counters to zero. On the first clock edge after reset is released, hdOut and vdOut both rise.
- R2: hdOut rises every LINE_CLKS clocks and stays high for HSYNC_CLKS clocks each time.
- R3: vdOut rises every LINE_CLKS*FRAME_LINES clocks and stays high for VSYNC_LINES*LINE_CLKS clocks. Every rise of vdOut falls on the same edge as a rise of hdOut.
- R4: With no hold, tgOut rises exactly TG_LINE*LINE_CLKS clocks after each rise of vdOut. It stays high for TG_CLKS clocks, occurs once per frame, and is never high together with vdOut.
- R5: The hold input holdN passes through a two-stage synchronizer. If its synchronized level is low (0) at a transfer slot while normalMode is 1, no tgOut pulse is issued in that frame.
- R6: Releasing holdN does not produce a transfer immediately. The next tgOut pulse comes at the next regular slot, so exposure is a whole number of frames. If the hold is asserted just after one pulse and released 1.5 frames later, the next pulse comes 2 frames after the previous one. If it is held for just over 2 frames, the next pulse comes 3 frames after the previous one.
- R7: integActive rises on the clock edge at which a withheld tgOut pulse would have risen. It falls on the same edge at which the releasing tgOut pulse rises. It is never high together with tgOut.
- R8: While normalMode is 0, holdN is ignored: tgOut pulses every frame and integActive stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous reset, active high |
| normalMode | input | 1 | 1 = the hold input is honoured, 0 = it is ignored |
| holdN | input | 1 | Exposure hold request, active low, asynchronous |
| hdOut | output | 1 | Horizontal sync strobe, once per line |
| vdOut | output | 1 | Vertical sync strobe, once per frame |
| tgOut | output | 1 | Transfer-gate strobe at the per-frame slot |
| integActive | output | 1 | High while transfers are being withheld |

## Verification
The bench uses the default parameters: 40-clock lines, 4-clock sync and transfer strobes, 16-line frames, a 3-line vertical strobe and the transfer slot on line 9. That makes a 640-clock frame, so holds lasting several frames and many frames of free-running timing fit within a short run. The short line still leaves hundreds of clocks between the vertical strobe and the slot. The bench can therefore change holdN well clear of the synchronizer latency and measure every pulse position against vdOut to the exact clock.

// File: rtl/exp_tg_pkg.sv
package exp_tg_pkg;

  // Timing events from the datapath counters to the control logic
  typedef struct packed {
    logic lineWrap;   // last clock of a line
    logic slotStart;  // first clock of the transfer line
  } tmEvt_t;

  // Strobes from control to the datapath
  typedef struct packed {
    logic tgAllow;    // transfer pulse may be driven this clock
  } ctrlStb_t;

endpackage

// File: rtl/exp_tg_timing.sv
module exp_tg_timing
  import exp_tg_pkg::*;
#(
  parameter int LINE_CLKS   = 40,
  parameter int HSYNC_CLKS  = 4,
  parameter int TG_CLKS     = 4,
  parameter int FRAME_LINES = 16,
  parameter int VSYNC_LINES = 3,
  parameter int TG_LINE     = 9
) (
  input  logic     clk,
  input  logic     rst,
  input  ctrlStb_t stb,
  output tmEvt_t   evt,
  output logic     hdOut,
  output logic     vdOut,
  output logic     tgOut
);

  localparam int HW = (LINE_CLKS   > 2) ? $clog2(LINE_CLKS)   : 1;
  localparam int VW = (FRAME_LINES > 2) ? $clog2(FRAME_LINES) : 1;
  localparam logic [HW-1:0] H_LAST = HW'(LINE_CLKS - 1);
  localparam logic [VW-1:0] V_LAST = VW'(FRAME_LINES - 1);
  localparam logic [VW-1:0] V_TG   = VW'(TG_LINE);

  logic [HW-1:0] hCnt;
  logic [VW-1:0] vCnt;
  logic hWrap, vWrap;
  logic hdWin, vdWin, tgWin;

  assign hWrap = (hCnt == H_LAST);
  assign vWrap = (vCnt == V_LAST);

  // Strobe windows decoded from the counters; the outputs register them
  always_comb begin
    hdWin = (32'(hCnt) < HSYNC_CLKS);
    vdWin = (32'(vCnt) < VSYNC_LINES);
    tgWin = (vCnt == V_TG) && (32'(hCnt) < TG_CLKS);
  end

  assign evt.lineWrap  = hWrap;
  assign evt.slotStart = (vCnt == V_TG) && (hCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hCnt <= '0;
      vCnt <= '0;
    end else begin
      hCnt <= hWrap ? '0 : hCnt + 1'b1;
      if (hWrap) vCnt <= vWrap ? '0 : vCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdOut <= 1'b0;
      vdOut <= 1'b0;
      tgOut <= 1'b0;
    end else begin
      hdOut <= hdWin;
      vdOut <= vdWin;
      tgOut <= tgWin && stb.tgAllow;
    end
  end

endmodule

// File: rtl/exp_tg_ctrl.sv
module exp_tg_ctrl
  import exp_tg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     normalMode,
  input  logic     holdN,
  input  tmEvt_t   evt,
  output ctrlStb_t stb,
  output logic     integActive
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic holdReq;
  logic passLatch;

  // Resynchronizer chain, idle level high
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '1;
        else     syncQ <= holdN;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '1;
        else     syncQ <= {syncQ[SYNC_STAGES-2:0], holdN};
      end
    end
  endgenerate

  assign holdReq = ~syncQ[SYNC_STAGES-1] & normalMode;

  // Decision taken once per frame, at the first clock of the slot line
  always_ff @(posedge clk) begin
    if (rst) begin
      passLatch   <= 1'b1;
      integActive <= 1'b0;
    end else if (evt.slotStart) begin
      passLatch   <= ~holdReq;
      integActive <= holdReq;
    end
  end

  assign stb.tgAllow = evt.slotStart ? ~holdReq : passLatch;

endmodule

// File: rtl/exp_tg_seq.sv
module exp_tg_seq
  import exp_tg_pkg::*;
#(
  parameter int LINE_CLKS   = 40,
  parameter int HSYNC_CLKS  = 4,
  parameter int TG_CLKS     = 4,
  parameter int FRAME_LINES = 16,
  parameter int VSYNC_LINES = 3,
  parameter int TG_LINE     = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic normalMode,
  input  logic holdN,
  output logic hdOut,
  output logic vdOut,
  output logic tgOut,
  output logic integActive
);

  tmEvt_t   evt;
  ctrlStb_t stb;

  exp_tg_timing #(
    .LINE_CLKS(LINE_CLKS), .HSYNC_CLKS(HSYNC_CLKS), .TG_CLKS(TG_CLKS),
    .FRAME_LINES(FRAME_LINES), .VSYNC_LINES(VSYNC_LINES), .TG_LINE(TG_LINE)
  ) u_timing (
    .clk(clk), .rst(rst), .stb(stb), .evt(evt),
    .hdOut(hdOut), .vdOut(vdOut), .tgOut(tgOut)
  );

  exp_tg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .normalMode(normalMode), .holdN(holdN),
    .evt(evt), .stb(stb), .integActive(integActive)
  );

endmodule

// File: rtl/exp_tg_seq_chk.sv
module exp_tg_seq_chk #(
  parameter int HSYNC_CLKS = 4,
  parameter int TG_CLKS    = 4
) (
  input logic clk,
  input logic rst,
  input logic hdOut,
  input logic vdOut,
  input logic tgOut,
  input logic integActive
);

  int hdRun;
  int tgRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      hdRun <= 0;
      tgRun <= 0;
    end else begin
      hdRun <= hdOut ? hdRun + 1 : 0;
      tgRun <= tgOut ? tgRun + 1 : 0;
    end
  end

  // R2: horizontal strobe never exceeds its width
  a_r2_hd_width: assert property (@(posedge clk) disable iff (rst)
    hdRun <= HSYNC_CLKS);

  // R3: vertical strobe starts together with a horizontal strobe
  a_r3_vd_on_hd: assert property (@(posedge clk) disable iff (rst)
    $rose(vdOut) |-> $rose(hdOut));

  // R4: transfer strobe bounded in width and never during vertical sync
  a_r4_tg_width: assert property (@(posedge clk) disable iff (rst)
    tgRun <= TG_CLKS);
  a_r4_tg_not_vd: assert property (@(posedge clk) disable iff (rst)
    tgOut |-> !vdOut);

  // R7: status and transfer exclusive; status drops only with a release pulse
  a_r7_excl: assert property (@(posedge clk) disable iff (rst)
    !(tgOut && integActive));
  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    $fell(integActive) |-> $rose(tgOut));

endmodule

bind exp_tg_seq exp_tg_seq_chk #(.HSYNC_CLKS(HSYNC_CLKS), .TG_CLKS(TG_CLKS)) u_chk (
  .clk(clk), .rst(rst), .hdOut(hdOut), .vdOut(vdOut),
  .tgOut(tgOut), .integActive(integActive)
);

// File: tb/exp_tg_seq_tb.sv
module exp_tg_seq_tb;

  localparam int LINE_CLKS   = 40;
  localparam int HSYNC_CLKS  = 4;
  localparam int TG_CLKS     = 4;
  localparam int FRAME_LINES = 16;
  localparam int VSYNC_LINES = 3;
  localparam int TG_LINE     = 9;
  localparam int FRAME       = LINE_CLKS * FRAME_LINES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic normalMode = 1'b1;
  logic holdN = 1'b1;
  logic hdOut, vdOut, tgOut, integActive;

  always #2.5 clk = ~clk;

  exp_tg_seq #(
    .LINE_CLKS(LINE_CLKS), .HSYNC_CLKS(HSYNC_CLKS), .TG_CLKS(TG_CLKS),
    .FRAME_LINES(FRAME_LINES), .VSYNC_LINES(VSYNC_LINES), .TG_LINE(TG_LINE)
  ) u_dut (
    .clk(clk), .rst(rst), .normalMode(normalMode), .holdN(holdN),
    .hdOut(hdOut), .vdOut(vdOut), .tgOut(tgOut), .integActive(integActive)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Edge monitor, sampled at the falling clock edge
  logic hdP = 0, vdP = 0, tgP = 0;
  int hdCnt = 0, vdCnt = 0, tgCnt = 0;
  int hdLast = 0, vdLast = 0, tgLast = 0;
  int hdRun = 0, vdRun = 0, tgRun = 0;
  int hdW = 0, vdW = 0, tgW = 0;

  always @(negedge clk) begin
    if (hdOut && !hdP) begin hdCnt++; hdLast = cyc; end
    if (vdOut && !vdP) begin vdCnt++; vdLast = cyc; end
    if (tgOut && !tgP) begin tgCnt++; tgLast = cyc; end
    if (!hdOut && hdP) hdW = hdRun;
    if (!vdOut && vdP) vdW = vdRun;
    if (!tgOut && tgP) tgW = tgRun;
    hdRun = hdOut ? hdRun + 1 : 0;
    vdRun = vdOut ? vdRun + 1 : 0;
    tgRun = tgOut ? tgRun + 1 : 0;
    hdP = hdOut; vdP = vdOut; tgP = tgOut;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitHd(output int t);
    int c = hdCnt;
    while (hdCnt == c) @(posedge clk);
    t = hdLast;
  endtask

  task automatic waitVd(output int t);
    int c = vdCnt;
    while (vdCnt == c) @(posedge clk);
    t = vdLast;
  endtask

  task automatic waitTg(output int t);
    int c = tgCnt;
    while (tgCnt == c) @(posedge clk);
    t = tgLast;
  endtask

  // R1: reset state and restart
  task automatic testReset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(!hdOut && !vdOut && !tgOut && !integActive, "R1 outputs in reset",
        {hdOut, vdOut, tgOut, integActive}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(hdOut && vdOut && !tgOut, "R1 first edge raises hd and vd",
        {hdOut, vdOut, tgOut}, 3'b110);
  endtask

  // R2: horizontal timing
  task automatic testHd();
    int t1, t2;
    waitHd(t1);
    waitHd(t2);
    chk(t2 - t1 == LINE_CLKS, "R2 hd period", t2 - t1, LINE_CLKS);
    chk(hdW == HSYNC_CLKS, "R2 hd width", hdW, HSYNC_CLKS);
  endtask

  // R3: vertical timing
  task automatic testVd();
    int t1, t2, th;
    waitVd(t1);
    th = hdLast;
    waitVd(t2);
    chk(t2 - t1 == FRAME, "R3 vd period", t2 - t1, FRAME);
    chk(vdW == VSYNC_LINES * LINE_CLKS, "R3 vd width", vdW, VSYNC_LINES * LINE_CLKS);
    chk(th == t1, "R3 vd rises with hd", th, t1);
  endtask

  // R4: transfer slot position, width, rate
  task automatic testTg();
    int tv, tt, c0, t9;
    waitVd(tv);
    waitTg(tt);
    chk(tt - tv == TG_LINE * LINE_CLKS, "R4 tg offset from vd", tt - tv, TG_LINE * LINE_CLKS);
    c0 = tgCnt;
    repeat (3 * FRAME) @(posedge clk);
    chk(tgCnt - c0 == 3, "R4 one tg per frame", tgCnt - c0, 3);
    chk(tgW == TG_CLKS, "R4 tg width", tgW, TG_CLKS);
    waitTg(t9);
  endtask

  // R5, R6, R7: 1.5-frame hold rounds up to 2 frames
  task automatic testHoldHalf();
    int t0, t1, c0;
    waitTg(t0);
    repeat (2) @(posedge clk);
    holdN = 1'b0;
    c0 = tgCnt;
    while (cyc < t0 + FRAME - 1) @(negedge clk);
    chk(integActive == 0, "R7 status low before first held slot", integActive, 0);
    @(negedge clk);
    chk(integActive == 1, "R7 status rises at held slot", integActive, 1);
    chk(tgOut == 0, "R5 held slot gives no tg", tgOut, 0);
    while (cyc < t0 + FRAME + FRAME / 2) @(negedge clk);
    chk(tgCnt == c0, "R5 no tg during hold", tgCnt - c0, 0);
    holdN = 1'b1;
    waitTg(t1);
    chk(t1 - t0 == 2 * FRAME, "R6 1.5 frames rounds to 2", t1 - t0, 2 * FRAME);
    @(negedge clk);
    chk(integActive == 0, "R7 status low at release pulse", integActive, 0);
  endtask

  // R6: hold past two slots, released just after the second
  task automatic testHoldTwo();
    int t0, t1;
    waitTg(t0);
    repeat (2) @(posedge clk);
    holdN = 1'b0;
    while (cyc < t0 + 2 * FRAME + 20) @(negedge clk);
    chk(integActive == 1, "R7 status held across frames", integActive, 1);
    holdN = 1'b1;
    waitTg(t1);
    chk(t1 - t0 == 3 * FRAME, "R6 release waits for next slot", t1 - t0, 3 * FRAME);
  endtask

  // R8: hold ignored outside normal mode
  task automatic testMode();
    int t0, t1, t2;
    waitTg(t0);
    normalMode = 1'b0;
    holdN = 1'b0;
    waitTg(t1);
    chk(t1 - t0 == FRAME, "R8 tg continues with hold outside normal mode", t1 - t0, FRAME);
    chk(integActive == 0, "R8 status stays low", integActive, 0);
    waitTg(t2);
    chk(t2 - t1 == FRAME, "R8 second frame still transfers", t2 - t1, FRAME);
    holdN = 1'b1;
    normalMode = 1'b1;
  endtask

  initial begin
    begin : wd
      fork
        begin
          repeat (150000) @(posedge clk);
          chk(0, "watchdog", cyc, 0);
        end
        begin
          testReset();
          testHd();
          testVd();
          testTg();
          testHoldHalf();
          testHoldTwo();
          testMode();
          // R1: reset in the middle of a hold clears status
          holdN = 1'b0;
          repeat (2 * FRAME) @(posedge clk);
          holdN = 1'b1;
          testReset();
        end
      join_any
      disable fork;
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule